// File: doc/BRIEF.md
# Priority-Level Interrupt Resolver

This block keeps the request, enable and priority state of the maskable interrupt groups of a processor's interrupt controller. Group identifiers 2 through 30 are maskable. Each group holds four sticky request bits, a four-bit enable mask and a three-bit priority level. An external capture stage turns raw interrupt lines into one-cycle set strobes, one strobe per request bit. A byte-wide register port reads and updates each group's two control bytes. It also reads back the group that the processor last accepted.

A combinational resolver looks at every group whose requests and enables overlap. The lowest level number wins, and on a tie the lowest group number wins. The resolver drives the winning level and group to the processor. Level 7 means that nothing is pending. When the processor takes an interrupt it pulses the acknowledge input together with the level it saw. The block then latches the current winner into the accepted-group register. A small two-state machine watches the acknowledge. In state ERR_CLEAN it moves to ERR_FAULT (transition "level mismatch") when the acknowledged level differs from the level presented. ERR_FAULT has a single transition, back to itself, so the flag holds until reset.

The register address has a window bit (bit 7) and two address windows. With bit 7 clear, the control window is selected: bits 6:2 give the group number and bits 1:0 give the byte within that group's slot. With bit 7 set, the accepted-group window is selected. All state is updated on the rising clock edge. The level, group and read data are combinational functions of that state and of the address.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset every request, enable, level and the accepted group are zero and sync_err is 0. As a result irq_lvl is 7 and irq_gid is 0, and every readable byte returns 0.
- R2: A set strobe on req_set bit (g-2)*4+i sets request bit i of group g from the next cycle on. The bit stays set until it is cleared through the register port.
- R3: A write to byte 0 of a group acts on each pair of bits (4+i, i). The pair 1,1 sets request i, the pair 0,1 clears it, and the pairs 1,0 and 0,0 leave it unchanged.
- R4: Reading byte 0 returns the raw requests in bits 7:4 and request AND enable in bits 3:0. Byte 1 holds the level in bits 6:4 and the enable mask in bits 3:0, reads back what was written, and returns 0 in bit 7.
- R5: Among the groups whose request AND enable is nonzero, the group with the numerically lowest level drives irq_lvl and irq_gid. These outputs change in the cycle after the strobe or write that causes the change.
- R6: When two or more competing groups share the lowest level, the lowest group number wins.
- R7: When no group competes, or only groups at level 7 compete, irq_lvl is 7 and irq_gid is 0.
- R8: An ack pulse latches irq_gid into the accepted-group register. Offset 0 of the accepted window returns the group number shifted left by 2 while that group still has request AND enable nonzero, and returns 0 otherwise. Every other offset of the window returns 0.
- R9: An ack whose ack_lvl differs from irq_lvl sets sync_err. sync_err then stays 1 until reset.
- R10: A set strobe and a byte-0 clear of the same bit in the same cycle leave the bit set.
- R11: Slots of group numbers 0, 1 and 31, bytes 2 and 3 of any slot, and the whole accepted window ignore writes and read as 0. Writes to them change neither irq_lvl nor irq_gid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | 116 | One-cycle set strobes, bit (g-2)*4+i for group g, request i |
| reg_wr | input | 1 | Register write enable for this cycle |
| reg_addr | input | 8 | Bit 7 selects the window; bits 6:2 group, 1:0 byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ack | input | 1 | Processor accepted the presented interrupt |
| ack_lvl | input | 3 | Level the processor believes it accepted |
| irq_lvl | output | 3 | Winning level, 7 when nothing is pending |
| irq_gid | output | 5 | Winning group number, 0 when nothing is pending |
| sync_err | output | 1 | Sticky flag for a mismatched acknowledge level |

## Verification
Two situations are hard to reach by chance. The first is a readback of an accepted group whose request has since gone away. The second is a tie at the winning level between groups that are far apart. Directed steps create both. They raise two groups at the same level, acknowledge the lower one, and then clear its only enabled bit with the 0,1 pair code before reading the accepted window. Seeded random steps then mix sparse strobes, pair-code writes, level and mask changes and correctly levelled acknowledges. Ties, competitors at level 7 and unmasked-but-disabled requests therefore come up many times. The sticky error is forced at the end with a deliberately wrong acknowledge level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int REQ_BITS = 4;
    localparam int LVL_BITS = 3;
    localparam int BYTE_W   = 8;

    typedef logic [REQ_BITS-1:0] req_vec_t;
    typedef logic [LVL_BITS-1:0] lvl_t;

    typedef struct packed {
        req_vec_t req;
        req_vec_t en;
        lvl_t     lvl;
    } grp_state_t;

    // Acknowledge consistency tracker states
    typedef enum logic {
        ERR_CLEAN = 1'b0,
        ERR_FAULT = 1'b1
    } ack_state_t;

    // Register address window
    typedef enum logic {
        WIN_CTRL   = 1'b0,
        WIN_ACCEPT = 1'b1
    } win_t;

    // Paired set/clear code: hi=1,lo=1 sets; hi=0,lo=1 clears; else keep
    function automatic req_vec_t apply_pair(req_vec_t cur, req_vec_t hi, req_vec_t lo);
        return (hi & lo) | (hi & cur) | (~hi & ~lo & cur);
    endfunction

endpackage

// File: rtl/prio_irq_group.sv
module prio_irq_group
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_cfg,
    input  logic [BYTE_W-1:0] wdata,
    input  req_vec_t          set_stb,
    output grp_state_t        st
);

    req_vec_t req_nxt;
    logic     unused_top_bit;

    assign unused_top_bit = wdata[BYTE_W-1];

    always_comb begin
        req_nxt = st.req;
        if (wr_req) begin
            req_nxt = apply_pair(st.req,
                                 wdata[2*REQ_BITS-1:REQ_BITS],
                                 wdata[REQ_BITS-1:0]);
        end
        // Capture strobes override a same-cycle clear
        req_nxt = req_nxt | set_stb;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            st.req <= req_nxt;
            if (wr_cfg) begin
                st.lvl <= wdata[REQ_BITS+LVL_BITS-1:REQ_BITS];
                st.en  <= wdata[REQ_BITS-1:0];
            end
        end
    end

    assert_strobe_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb != '0) |=> ((st.req & $past(set_stb)) == $past(set_stb)));

    assert_cfg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (st.en == $past(wdata[REQ_BITS-1:0]))
                && (st.lvl == $past(wdata[REQ_BITS+LVL_BITS-1:REQ_BITS])));

    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !wr_cfg && set_stb == '0) |=> $stable(st));

    assert_strobe_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && set_stb != '0) |=> ((st.req & $past(set_stb)) != '0));

endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
    import prio_irq_pkg::*;
#(
    parameter int N_MASK     = 29,
    parameter int FIRST_MASK = 2,
    parameter int GID_W      = 5
)(
    input  grp_state_t [N_MASK-1:0] grp,
    output lvl_t                    win_lvl,
    output logic [GID_W-1:0]        win_gid
);

    always_comb begin
        win_lvl = '1;
        win_gid = '0;
        // Strict compare keeps the lowest group number on a tie
        for (int k = 0; k < N_MASK; k++) begin
            if (((grp[k].req & grp[k].en) != '0) && (grp[k].lvl < win_lvl)) begin
                win_lvl = grp[k].lvl;
                win_gid = GID_W'(k + FIRST_MASK);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ack.sv
module prio_irq_ack
    import prio_irq_pkg::*;
#(
    parameter int GID_W = 5
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    input  lvl_t             ack_lvl,
    input  lvl_t             cur_lvl,
    input  logic [GID_W-1:0] cur_gid,
    output logic [GID_W-1:0] acc_gid,
    output logic             err
);

    ack_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ERR_CLEAN;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        unique case (state)
            ERR_CLEAN: state_nxt = (ack && (ack_lvl != cur_lvl)) ? ERR_FAULT : ERR_CLEAN;
            ERR_FAULT: state_nxt = ERR_FAULT;
        endcase
    end

    always_comb begin
        unique case (state)
            ERR_CLEAN: err = 1'b0;
            ERR_FAULT: err = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_gid <= '0;
        end else if (ack) begin
            acc_gid <= cur_gid;
        end
    end

    assert_latch_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (acc_gid == $past(cur_gid)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_err_on_mismatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (ack_lvl != cur_lvl)) |=> err);

endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int N_IDS      = 31,
    parameter int FIRST_MASK = 2,
    parameter int ADDR_W     = 8,
    localparam int N_MASK    = N_IDS - FIRST_MASK,
    localparam int GID_W     = $clog2(N_IDS),
    localparam int STB_W     = N_MASK * REQ_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STB_W-1:0]  req_set,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ack,
    input  logic [LVL_BITS-1:0] ack_lvl,
    output logic [LVL_BITS-1:0] irq_lvl,
    output logic [GID_W-1:0]  irq_gid,
    output logic              sync_err
);

    localparam int SLOT_W = ADDR_W - 3;

    win_t                    win;
    logic [SLOT_W-1:0]       slot;
    logic [1:0]              byte_sel;
    grp_state_t [N_MASK-1:0] grp;
    logic [N_MASK-1:0]       wr_req, wr_cfg;
    logic [GID_W-1:0]        acc_gid;

    assign win      = win_t'(reg_addr[ADDR_W-1]);
    assign slot     = reg_addr[ADDR_W-2:2];
    assign byte_sel = reg_addr[1:0];

    for (genvar k = 0; k < N_MASK; k++) begin : g_grp
        assign wr_req[k] = reg_wr && (win == WIN_CTRL)
                        && (slot == SLOT_W'(k + FIRST_MASK)) && (byte_sel == 2'd0);
        assign wr_cfg[k] = reg_wr && (win == WIN_CTRL)
                        && (slot == SLOT_W'(k + FIRST_MASK)) && (byte_sel == 2'd1);

        prio_irq_group u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_req  (wr_req[k]),
            .wr_cfg  (wr_cfg[k]),
            .wdata   (reg_wdata),
            .set_stb (req_set[k*REQ_BITS +: REQ_BITS]),
            .st      (grp[k])
        );
    end

    prio_irq_select #(
        .N_MASK     (N_MASK),
        .FIRST_MASK (FIRST_MASK),
        .GID_W      (GID_W)
    ) u_sel (
        .grp     (grp),
        .win_lvl (irq_lvl),
        .win_gid (irq_gid)
    );

    prio_irq_ack #(
        .GID_W (GID_W)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ack),
        .ack_lvl (ack_lvl),
        .cur_lvl (irq_lvl),
        .cur_gid (irq_gid),
        .acc_gid (acc_gid),
        .err     (sync_err)
    );

    // Read path
    grp_state_t sel_st, acc_st, win_st;
    logic       sel_hit;

    always_comb begin
        sel_st  = '0;
        acc_st  = '0;
        win_st  = '0;
        sel_hit = 1'b0;
        for (int k = 0; k < N_MASK; k++) begin
            if (slot == SLOT_W'(k + FIRST_MASK)) begin
                sel_st  = grp[k];
                sel_hit = 1'b1;
            end
            if (acc_gid == GID_W'(k + FIRST_MASK)) acc_st = grp[k];
            if (irq_gid == GID_W'(k + FIRST_MASK)) win_st = grp[k];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (win)
            WIN_CTRL: begin
                if (sel_hit) begin
                    unique case (byte_sel)
                        2'd0:    reg_rdata = {sel_st.req, sel_st.req & sel_st.en};
                        2'd1:    reg_rdata = {1'b0, sel_st.lvl, sel_st.en};
                        default: reg_rdata = '0;
                    endcase
                end
            end
            WIN_ACCEPT: begin
                if ((reg_addr[ADDR_W-2:0] == '0) && ((acc_st.req & acc_st.en) != '0))
                    reg_rdata = BYTE_W'(acc_gid) << 2;
            end
        endcase
    end

    assert_idle_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl == '1) == (irq_gid == '0));

    assert_winner_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_gid != '0) |-> (((win_st.req & win_st.en) != '0) && (win_st.lvl == irq_lvl)));

    assert_accept_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win == WIN_ACCEPT) |-> (reg_rdata[1:0] == 2'b00));

endmodule

// File: tb/tb_prio_irq_resolver.sv
module tb_prio_irq_resolver;

    localparam int NB = 116;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req_set = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          ack = 1'b0;
    logic [2:0]    ack_lvl = '0;
    logic [2:0]    irq_lvl;
    logic [4:0]    irq_gid;
    logic          sync_err;

    prio_irq_resolver dut (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack(ack), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl), .irq_gid(irq_gid),
        .sync_err(sync_err)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_req[32], m_en[32], m_lvl[32];
    int m_acc, m_err;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int win_pack();
        int bl = 7;
        int bg = 0;
        for (int g = 2; g <= 30; g++)
            if (((m_req[g] & m_en[g]) != 0) && (m_lvl[g] < bl)) begin
                bl = m_lvl[g];
                bg = g;
            end
        return bl * 32 + bg;
    endfunction

    function automatic int exp_read(logic [7:0] a);
        int g = int'(a[6:2]);
        int b = int'(a[1:0]);
        if (!a[7]) begin
            if (g < 2 || g > 30) return 0;
            if (b == 0) return (m_req[g] << 4) | (m_req[g] & m_en[g]);
            if (b == 1) return (m_lvl[g] << 4) | m_en[g];
            return 0;
        end
        if (a[6:0] != 0) return 0;
        if ((m_req[m_acc] & m_en[m_acc]) != 0) return m_acc << 2;
        return 0;
    endfunction

    function automatic void model_update(bit wr, logic [7:0] a, logic [7:0] d,
                                         logic [NB-1:0] s, bit ak, int al);
        int w = win_pack();
        int g = int'(a[6:2]);
        if (ak) begin
            m_acc = w % 32;
            if (al != w / 32) m_err = 1;
        end
        if (wr && !a[7] && g >= 2 && g <= 30) begin
            if (a[1:0] == 2'd0) begin
                int hi = int'(d[7:4]);
                int lo = int'(d[3:0]);
                m_req[g] = ((hi & lo) | (hi & m_req[g]) | (~hi & ~lo & m_req[g])) & 15;
            end else if (a[1:0] == 2'd1) begin
                m_lvl[g] = int'(d[6:4]);
                m_en[g]  = int'(d[3:0]);
            end
        end
        for (int q = 2; q <= 30; q++)
            m_req[q] |= int'(s[(q-2)*4 +: 4]);
    endfunction

    function automatic logic [7:0] ga(int g, int b);
        return {1'b0, 5'(g), 2'(b)};
    endfunction

    function automatic logic [NB-1:0] sb(int g, int b);
        logic [NB-1:0] r = '0;
        r[(g-2)*4 + b] = 1'b1;
        return r;
    endfunction

    task automatic check_outs(string tag);
        int w = win_pack();
        chk(tag, "irq_lvl", int'(irq_lvl), w / 32);
        chk(tag, "irq_gid", int'(irq_gid), w % 32);
        chk("R9", "sync_err", int'(sync_err), m_err);
    endtask

    // otag names what the outputs show from the previous step; rtag the read
    task automatic step(bit wr, logic [7:0] a, logic [7:0] d, logic [NB-1:0] s,
                        bit ak, int al, string otag, string rtag);
        @(negedge clk);
        check_outs(otag);
        reg_wr = wr; reg_addr = a; reg_wdata = d; req_set = s;
        ack = ak; ack_lvl = 3'(al);
        #1;
        chk(rtag, "reg_rdata", int'(reg_rdata), exp_read(a));
        model_update(wr, a, d, s, ak, al);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 0; req_set = '0; ack = 0;
        repeat (3) @(negedge clk);
        for (int g = 0; g < 32; g++) begin
            m_req[g] = 0; m_en[g] = 0; m_lvl[g] = 0;
        end
        m_acc = 0; m_err = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w;
        void'($urandom(32'hC0FFEE));
        do_reset();
        // R1 reset state
        step(0, ga(5,1), 0, '0, 0, 0, "R1", "R1");
        step(0, 8'h80,   0, '0, 0, 0, "R1", "R1");
        step(0, ga(30,0), 0, '0, 0, 0, "R1", "R1");
        // R7 only a level-7 competitor
        step(1, ga(20,1), 8'h7F, '0, 0, 0, "R1", "R4");
        step(0, ga(20,1), 0, sb(20,2), 0, 0, "R1", "R4");
        step(0, ga(20,0), 0, '0, 0, 0, "R7", "R2");
        // R5 first real winner
        step(1, ga(5,1), 8'h3F, '0, 0, 0, "R7", "R4");
        step(0, ga(5,0), 0, sb(5,1), 0, 0, "R7", "R2");
        step(0, ga(5,0), 0, '0, 0, 0, "R5", "R2");
        // R5 lower level beats it
        step(1, ga(9,1), 8'h11, '0, 0, 0, "R5", "R4");
        step(0, ga(9,0), 0, sb(9,0), 0, 0, "R5", "R4");
        step(0, ga(9,0), 0, '0, 0, 0, "R5", "R2");
        // R6 tie at level 1, group 4 below group 9
        step(1, ga(4,1), 8'h11, '0, 0, 0, "R5", "R4");
        step(0, ga(4,0), 0, sb(4,0), 0, 0, "R5", "R2");
        step(0, 8'h80, 0, '0, 1, 1, "R6", "R8");
        // R8 accepted group readback, then lost
        step(0, 8'h80, 0, '0, 0, 0, "R8", "R8");
        step(1, ga(4,0), 8'h01, '0, 0, 0, "R8", "R3");
        step(0, 8'h80, 0, '0, 0, 0, "R3", "R8");
        step(0, 8'h81, 0, '0, 0, 0, "R3", "R8");
        // R3 pair codes on group 9
        step(1, ga(9,0), 8'h88, '0, 0, 0, "R5", "R3");
        step(1, ga(9,0), 8'h40, '0, 0, 0, "R3", "R3");
        step(1, ga(9,0), 8'h00, '0, 0, 0, "R3", "R3");
        step(0, ga(9,0), 0, '0, 0, 0, "R3", "R3");
        // R10 strobe against same-cycle clear
        step(1, ga(9,0), 8'h01, sb(9,0), 0, 0, "R3", "R10");
        step(0, ga(9,0), 0, '0, 0, 0, "R10", "R10");
        // R11 unmapped writes
        step(1, ga(1,1), 8'h0F, '0, 0, 0, "R10", "R11");
        step(1, ga(31,1), 8'h0F, '0, 0, 0, "R11", "R11");
        step(1, ga(9,2), 8'hFF, '0, 0, 0, "R11", "R11");
        step(1, 8'h80, 8'hFF, '0, 0, 0, "R11", "R8");
        step(1, ga(0,0), 8'hFF, '0, 0, 0, "R11", "R11");
        step(0, ga(1,1), 0, '0, 0, 0, "R11", "R11");
        step(0, ga(31,1), 0, '0, 0, 0, "R11", "R11");
        step(0, ga(9,2), 0, '0, 0, 0, "R11", "R11");
        // Seeded random mix
        for (int n = 0; n < 800; n++) begin
            bit wr = ($urandom_range(3) == 0);
            logic [7:0] a;
            logic [7:0] d = 8'($urandom);
            logic [NB-1:0] s = '0;
            bit ak = ($urandom_range(7) == 0);
            string rt;
            if (wr) a = ga($urandom_range(30, 2), $urandom_range(1));
            else if ($urandom_range(3) == 0) a = 8'h80;
            else a = 8'($urandom);
            if ($urandom_range(2) == 0) s = sb($urandom_range(30, 2), $urandom_range(3));
            w = win_pack();
            rt = a[7] ? "R8" : "R4";
            step(wr, a, d, s, ak, w / 32, "R5", rt);
        end
        // R9 wrong acknowledge level, then sticky
        w = win_pack();
        step(0, 8'h80, 0, '0, 1, (w / 32 + 1) % 8, "R5", "R8");
        step(0, 8'h80, 0, '0, 0, 0, "R9", "R8");
        step(0, 8'h80, 0, '0, 1, win_pack() / 32, "R9", "R8");
        step(0, 8'h80, 0, '0, 0, 0, "R9", "R8");
        chk("R9", "sync_err_held", int'(sync_err), 1);
        do_reset();
        step(0, 8'h80, 0, '0, 0, 0, "R1", "R1");
        step(0, ga(9,0), 0, '0, 0, 0, "R1", "R1");
        @(negedge clk);
        check_outs("R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule